// File: doc/BRIEF.md
# Pre-indexed indirect address generator

This block forms the effective memory address for an instruction that applies indexing first and then indirection. The instruction supplies an 8-bit signed displacement and names one of several index registers. The block sign-extends the displacement and adds it to the chosen register. The result is a 16-bit intermediate address. In indirect mode that address points at a pointer word. The block reads that word over a simple request/valid port and returns it as the effective address.

A mode input also allows plain indexed addressing. In that mode the intermediate address is itself the result, and no memory access takes place. Each operation begins with a one-cycle start strobe and ends with a one-cycle done strobe. The effective address stays on its output until the next operation completes. The register file, the memory and the instruction decoder sit outside this block.

Top module: `idxind_addr_gen`

## Requirements
- R1: The 8-bit displacement is a two's-complement number and is sign-extended to 16 bits before the addition. For example, 0x80 counts as -128 and 0x7F as +127.
- R2: The intermediate address is (index + extended displacement) mod 2^16, and any carry out of bit 15 is lost. Two examples: 0x1042 with 0x9D gives 0x0FDF, and 0xFFF0 with 0x7F gives 0x006F.
- R3: A start accepted with `indirect_i`=0 raises `done_o` in the cycle after the start edge. `ea_o` then holds the intermediate address, and `rd_req_o` stays low for the whole operation.
- R4: A start accepted with `indirect_i`=1 raises `rd_req_o` in the cycle after the start edge, with `rd_addr_o` equal to the intermediate address. Both stay unchanged until a clock edge at which `rd_valid_i` is high.
- R5: At the edge where `rd_req_o` and `rd_valid_i` are both high, `rd_data_i` is captured. In the next cycle `done_o` is high, `rd_req_o` is low and `ea_o` equals the captured word. For example, pointer word 0x217A at address 0x0FDF gives `ea_o`=0x217A.
- R6: `done_o` is high for exactly one cycle per operation. `ea_o` keeps its value until the next operation completes.
- R7: A start is taken only when the block is idle. A start that arrives while a read is outstanding, or in the done cycle, changes neither the pending address nor the result.
- R8: While the synchronous active-high reset `rst` is asserted, the block returns to idle at the next clock edge, with `rd_req_o`=0, `done_o`=0 and `ea_o`=0. This also applies in the middle of a read.
- R9: `idx_sel_i`=i selects the index value at bits [16*i+15 : 16*i] of `idx_regs_i`.
- R10: `rd_valid_i` is ignored when no read is outstanding. It leaves `done_o` low and `ea_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts an address computation |
| indirect_i | input | 1 | 1: indexed then indirect; 0: indexed only |
| disp_i | input | 8 | Signed displacement |
| idx_sel_i | input | 2 | Index register select |
| idx_regs_i | input | 64 | Packed index register values, register i in bits [16*i+15:16*i] |
| rd_req_o | output | 1 | Pointer read request |
| rd_addr_o | output | 16 | Pointer read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Pointer word returned by memory |
| ea_o | output | 16 | Effective address |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Directed cases cover negative, positive and extreme displacements (0x80, 0x7F, 0x9D), so that sign extension can be told apart from zero extension. Sums that cross 0xFFFF confirm that the carry is dropped. Random operations mix both modes, all four register selects and read latencies from zero to several cycles. These separate a result taken from the sum from one taken from the memory word, and show the request address staying stable through the wait. Starts injected during a wait, stray valid pulses while idle, and a reset in the middle of a read confirm that each is ignored or cleans up as required.

// File: rtl/idxind_pkg.sv
package idxind_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_WAIT = 2'd1,
    AG_DONE = 2'd2
  } ag_state_t;

endpackage

// File: rtl/idxind_index_sum.sv
module idxind_index_sum #(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 8,
  parameter int NUM_IDX = 4,
  localparam int SEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic [NUM_IDX*ADDR_W-1:0] idx_regs_i,
  input  logic [SEL_W-1:0]          idx_sel_i,
  input  logic [DISP_W-1:0]         disp_i,
  output logic [ADDR_W-1:0]         sum_o
);

  // Sign extension of the displacement (R1)
  function automatic logic [ADDR_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  // Modulo-2^ADDR_W add, carry dropped (R2)
  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] idx_arr [NUM_IDX];

  // Unpack the index register bank (R9)
  for (genvar gi = 0; gi < NUM_IDX; gi++) begin : g_unpack
    assign idx_arr[gi] = idx_regs_i[gi*ADDR_W +: ADDR_W];
  end

  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] ext_disp_w;

  assign base_w     = idx_arr[idx_sel_i];
  assign ext_disp_w = widen_disp(disp_i);
  assign sum_o      = wrap_add(base_w, ext_disp_w);

endmodule

// File: rtl/idxind_ctrl.sv
module idxind_ctrl
  import idxind_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              indirect_i,
  input  logic [ADDR_W-1:0] sum_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              done_o
);

  ag_state_t         state_q, state_d;
  logic [ADDR_W-1:0] ptr_addr_q;
  logic [ADDR_W-1:0] ea_q;

  // Named internal events
  logic accept_w;      // start taken in idle
  logic accept_dir_w;  // direct indexed start
  logic accept_ind_w;  // indirect start
  logic rd_fire_w;     // read handshake completes

  assign accept_w     = (state_q == AG_IDLE) && start_i;
  assign accept_dir_w = accept_w && !indirect_i;
  assign accept_ind_w = accept_w && indirect_i;
  assign rd_fire_w    = (state_q == AG_WAIT) && rd_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AG_IDLE: begin
        if (accept_dir_w)      state_d = AG_DONE;
        else if (accept_ind_w) state_d = AG_WAIT;
      end
      AG_WAIT: if (rd_fire_w) state_d = AG_DONE;
      AG_DONE: state_d = AG_IDLE;
      default: state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= AG_IDLE;
      ptr_addr_q <= '0;
      ea_q       <= '0;
    end else begin
      state_q <= state_d;
      if (accept_ind_w) ptr_addr_q <= sum_i;
      if (accept_dir_w) ea_q <= sum_i;
      else if (rd_fire_w) ea_q <= rd_data_i;
    end
  end

  assign rd_req_o  = (state_q == AG_WAIT);
  assign rd_addr_o = ptr_addr_q;
  assign ea_o      = ea_q;
  assign done_o    = (state_q == AG_DONE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o))); // R4

  AST_IND_ADDR: assert property (@(posedge clk) disable iff (rst)
    accept_ind_w |=> (rd_req_o && rd_addr_o == $past(sum_i))); // R4

  AST_FIRE_DONE: assert property (@(posedge clk) disable iff (rst)
    rd_fire_w |=> (done_o && !rd_req_o && ea_o == $past(rd_data_i))); // R5

  AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (rst)
    accept_dir_w |=> (done_o && !rd_req_o && ea_o == $past(sum_i))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i && start_i) |=> (rd_req_o && $stable(rd_addr_o))); // R7

  AST_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    (!rd_req_o && !done_o && !start_i && rd_valid_i) |=> (!done_o && $stable(ea_o))); // R10

endmodule

// File: rtl/idxind_addr_gen.sv
module idxind_addr_gen #(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 8,
  parameter int NUM_IDX = 4,
  localparam int SEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      indirect_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic [SEL_W-1:0]          idx_sel_i,
  input  logic [NUM_IDX*ADDR_W-1:0] idx_regs_i,
  output logic                      rd_req_o,
  output logic [ADDR_W-1:0]         rd_addr_o,
  input  logic                      rd_valid_i,
  input  logic [ADDR_W-1:0]         rd_data_i,
  output logic [ADDR_W-1:0]         ea_o,
  output logic                      done_o
);

  logic [ADDR_W-1:0] sum_w;

  idxind_index_sum #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .NUM_IDX(NUM_IDX)
  ) u_sum (
    .idx_regs_i(idx_regs_i),
    .idx_sel_i (idx_sel_i),
    .disp_i    (disp_i),
    .sum_o     (sum_w)
  );

  idxind_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .indirect_i(indirect_i),
    .sum_i     (sum_w),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_valid_i(rd_valid_i),
    .rd_data_i (rd_data_i),
    .ea_o      (ea_o),
    .done_o    (done_o)
  );

endmodule

// File: tb/idxind_addr_gen_tb.sv
module idxind_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        indirect_i = 1'b0;
  logic [7:0]  disp_i = '0;
  logic [1:0]  idx_sel_i = '0;
  logic [63:0] idx_regs_i = '0;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic [15:0] ea_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  idxind_addr_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .indirect_i(indirect_i),
    .disp_i(disp_i), .idx_sel_i(idx_sel_i), .idx_regs_i(idx_regs_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .ea_o(ea_o), .done_o(done_o)
  );

  // Reference: signed displacement as an integer, then wrap to 16 bits
  function automatic logic [15:0] ref_addr(input logic [15:0] base, input logic [7:0] d);
    int sv;
    sv = (d >= 8'h80) ? int'(d) - 256 : int'(d);
    return 16'((int'(base) + sv + 65536) % 65536);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_reg(input int i, input logic [15:0] v);
    idx_regs_i[i*16 +: 16] = v;
  endtask

  // One operation; lat = wait cycles before valid; poke = start during wait
  task automatic run_op(input bit ind, input logic [1:0] sel, input logic [7:0] d,
                        input logic [15:0] mem, input int lat, input bit poke);
    logic [15:0] exp_a;
    exp_a = ref_addr(idx_regs_i[sel*16 +: 16], d);
    @(negedge clk);
    start_i = 1'b1; indirect_i = ind; idx_sel_i = sel; disp_i = d;
    @(negedge clk);
    start_i = 1'b0;
    if (!ind) begin
      chk(done_o && !rd_req_o, "R3 done/no-req", {14'd0, rd_req_o, done_o}, 16'h0001);
      chk(ea_o == exp_a, "R3 R1 R2 R9 direct ea", ea_o, exp_a);
    end else begin
      chk(rd_req_o && !done_o, "R4 req raised", {14'd0, rd_req_o, done_o}, 16'h0002);
      chk(rd_addr_o == exp_a, "R4 R1 R2 R9 rd_addr", rd_addr_o, exp_a);
      for (int k = 0; k < lat; k++) begin
        if (poke) begin
          start_i = 1'b1; indirect_i = 1'b0; disp_i = d + 8'd17;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_req_o && rd_addr_o == exp_a, poke ? "R7 busy start" : "R4 hold", rd_addr_o, exp_a);
      end
      rd_valid_i = 1'b1; rd_data_i = mem;
      @(negedge clk);
      rd_valid_i = 1'b0; rd_data_i = ~mem;
      chk(done_o && !rd_req_o, "R5 done after valid", {14'd0, rd_req_o, done_o}, 16'h0001);
      chk(ea_o == mem, "R5 ea from memory", ea_o, mem);
      exp_a = mem;
    end
    if (poke) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !rd_req_o, "R6 R7 single done", {14'd0, rd_req_o, done_o}, 16'h0000);
    chk(ea_o == exp_a, "R6 ea held", ea_o, exp_a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req_o && !done_o && ea_o == 16'h0, "R8 reset state", ea_o, 16'h0);

    // Worked example: 0x1042 + 0x9D -> 0x0FDF, pointer 0x217A
    set_reg(2, 16'h1042);
    run_op(1'b0, 2'd2, 8'h9D, 16'h0, 0, 1'b0);
    run_op(1'b1, 2'd2, 8'h9D, 16'h217A, 2, 1'b0);
    // Extremes of the displacement and wraparound
    set_reg(0, 16'hFFF0); set_reg(1, 16'h0005); set_reg(3, 16'h8000);
    run_op(1'b0, 2'd0, 8'h7F, 16'h0, 0, 1'b0);   // R2 -> 0x006F
    run_op(1'b0, 2'd1, 8'h80, 16'h0, 0, 1'b0);   // R1 -> 0xFF85
    run_op(1'b0, 2'd3, 8'h80, 16'h0, 0, 1'b0);   // R1 -> 0x7F80
    run_op(1'b1, 2'd0, 8'h10, 16'hBEEF, 0, 1'b0); // R2 -> 0x0000, zero latency
    // Starts during the wait are ignored
    run_op(1'b1, 2'd1, 8'h33, 16'h1357, 3, 1'b1);

    // R10: stray valid while idle
    @(negedge clk);
    rd_valid_i = 1'b1; rd_data_i = 16'hDEAD;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(!done_o && ea_o == 16'h1357, "R10 stray valid", ea_o, 16'h1357);

    // R8: reset in the middle of a read
    @(negedge clk);
    start_i = 1'b1; indirect_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!rd_req_o && !done_o && ea_o == 16'h0, "R8 reset mid-read", {rd_req_o, done_o, ea_o[13:0]}, 16'h0);
    rd_valid_i = 1'b1; rd_data_i = 16'h4242;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(!done_o && ea_o == 16'h0, "R10 valid after reset", ea_o, 16'h0);

    // Random operations
    for (int t = 0; t < 300; t++) begin
      for (int r = 0; r < 4; r++) set_reg(r, 16'($urandom));
      run_op(1'($urandom), 2'($urandom), 8'($urandom), 16'($urandom),
             int'($urandom % 5), 1'($urandom % 4 == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule